// File: doc/BRIEF.md
# Gated Interval Timer

A 16-bit counter-timer behind a small register port. Software picks one of four tick sources: every bus clock, every 16th bus clock, every 256th bus clock, or each rising edge of an external horizontal-blank strobe. The count advances on each tick while the run bit is set. A compare register can send the count back to zero. When a match or a wrap from 0xFFFF to 0 occurs, a sticky flag is raised, and either flag can drive the interrupt line.

A gate input, or the blank strobe chosen in its place, can qualify counting by its level or clear the count on its edges. In builds with the capture register enabled, a capture pulse copies the live count into that register. The usual start-up sequence writes the mode word first and then writes zero to the count.

Top module: `gated_interval_timer`

## Requirements
- R1: The registers sit at byte offsets 0x00 (count), 0x10 (mode), 0x20 (compare) and 0x30 (capture). Any other offset reads zero. Read data bits [31:16] are always zero, and all registers reset to zero.
- R2: A write to the count register loads wdata[15:0] at that clock edge, overriding any tick. It also restarts the clock prescaler.
- R3: The count changes on a tick only while mode bit 7 (run) is 1. With run at 0, the count holds its value.
- R4: Mode bits [1:0] select the tick source. 0 ticks every clock. 1 ticks once per 16 clocks, the first tick coming on the 16th edge after a count write. 2 ticks once per 256 clocks on the same rule. 3 ticks on each rising edge of hblank.
- R5: With mode bit 6 (zero-return) set, a tick while count equals compare loads 0 and sets the equal flag, mode bit 10.
- R6: With zero-return clear, a tick while count equals compare sets the equal flag and the count still increments.
- R7: A tick at 0xFFFF without a zero-return match wraps the count to 0 and sets the overflow flag, mode bit 11.
- R8: Writing 1 to mode bit 10 or bit 11 clears that flag. Writing 0 leaves it unchanged, and a flag set in the same cycle stays set.
- R9: irq is high exactly when (bit 10 and bit 8) or (bit 11 and bit 9).
- R10: Mode bit 2 enables gating, and bit 3 picks the gate signal (0 = gate_in, 1 = hblank). Gate mode bits [5:4] select the behaviour. Mode 0 counts only while the gate is low. Modes 1, 2 and 3 clear the count on a rising edge, a falling edge, or either edge of the gate.
- R11: With HAS_HOLD = 1, a capture pulse copies the count into the capture register at that edge. Writes to offset 0x30 are always ignored. With HAS_HOLD = 0, offset 0x30 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset within the timer window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| hblank | input | 1 | Horizontal-blank strobe |
| gate_in | input | 1 | External gate |
| capture | input | 1 | Capture pulse for the capture register |
| irq | output | 1 | Interrupt request |

## Verification
Register writes and ticks take effect at the edge where they are seen, and reads are combinational. Each read is therefore sampled at the falling edge after the last edge that mattered, and counts are predicted by numbering those edges from the write that restarted the count. The divided sources are predicted in the same way: their first tick falls on the 16th or 256th edge after a count write. Flags and irq follow one edge after the tick that raises them. Edge-sensitive gate clears land on the edge that first sees the new gate level. The scoreboard's expected items are queued in stimulus order, so each comparison happens at exactly that sample point.

// File: rtl/git_pkg.sv
package git_pkg;
    localparam int MODE_W = 12;

    typedef enum logic [1:0] {
        SRC_BUS    = 2'd0,
        SRC_DIV_LO = 2'd1,
        SRC_DIV_HI = 2'd2,
        SRC_HBLANK = 2'd3
    } tick_src_e;

    typedef enum logic [1:0] {
        GATE_LEVEL = 2'd0,
        GATE_RISE  = 2'd1,
        GATE_FALL  = 2'd2,
        GATE_BOTH  = 2'd3
    } gate_mode_e;

    // Packed from bit 11 down to bit 0; software decodes these positions.
    typedef struct packed {
        logic       ovf;
        logic       equ;
        logic       ovf_ie;
        logic       cmp_ie;
        logic       run;
        logic       zret;
        gate_mode_e gmode;
        logic       gsrc;
        logic       gen;
        tick_src_e  src;
    } mode_t;
endpackage

// File: rtl/git_tick_src.sv
module git_tick_src
    import git_pkg::*;
#(
    parameter int LO_LOG2 = 4,
    parameter int HI_LOG2 = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  tick_src_e src,
    input  logic      hblank,
    output logic      tick
);
    typedef struct packed {
        logic [HI_LOG2-1:0] presc;
        logic               hb_prev;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.presc   = restart ? '0 : s_q.presc + 1'b1;
        s_d.hb_prev = hblank;
    end

    always_comb begin
        unique case (src)
            SRC_BUS:    tick = 1'b1;
            SRC_DIV_LO: tick = &s_q.presc[LO_LOG2-1:0];
            SRC_DIV_HI: tick = &s_q.presc;
            default:    tick = hblank & ~s_q.hb_prev;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/git_gate.sv
module git_gate
    import git_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gen,
    input  logic       gsrc,
    input  gate_mode_e gmode,
    input  logic       gate_in,
    input  logic       hblank,
    output logic       allow,
    output logic       clear
);
    logic gate_lvl;
    logic prev_d, prev_q;
    logic rise, fall;

    assign gate_lvl = gsrc ? hblank : gate_in;
    assign rise     = gate_lvl & ~prev_q;
    assign fall     = ~gate_lvl & prev_q;

    always_comb begin
        prev_d = gate_lvl;
        allow  = 1'b1;
        clear  = 1'b0;
        if (gen) begin
            unique case (gmode)
                GATE_LEVEL: allow = ~gate_lvl;
                GATE_RISE:  clear = rise;
                GATE_FALL:  clear = fall;
                default:    clear = rise | fall;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/gated_interval_timer.sv
module gated_interval_timer
    import git_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter bit HAS_HOLD    = 1'b1,
    parameter int DIV_LO_LOG2 = 4,
    parameter int DIV_HI_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              hblank,
    input  logic              gate_in,
    input  logic              capture,
    output logic              irq
);
    localparam int SEL_LSB = 4;
    localparam int SEL_MSB = SEL_LSB + 1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] comp;
        logic [CNT_W-1:0] hold;
        mode_t            mode;
    } tmr_st_t;

    tmr_st_t s_d, s_q;

    logic       hit;
    logic [1:0] sel;
    logic       wr_cnt, wr_mode, wr_cmp;
    logic       tick, gate_allow, gate_clear;
    logic       step, match, at_top, equ_set, ovf_set;
    mode_t      mode_wr;
    logic [CNT_W-1:0] hold_rd;
    logic       unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:CNT_W];
    assign sel     = addr[SEL_MSB:SEL_LSB];
    assign hit     = (addr[ADDR_W-1:SEL_MSB+1] == '0) && (addr[SEL_LSB-1:0] == '0);
    assign wr_cnt  = wr_en && hit && (sel == 2'd0);
    assign wr_mode = wr_en && hit && (sel == 2'd1);
    assign wr_cmp  = wr_en && hit && (sel == 2'd2);
    assign mode_wr = mode_t'(wdata[MODE_W-1:0]);

    git_tick_src #(.LO_LOG2(DIV_LO_LOG2), .HI_LOG2(DIV_HI_LOG2)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_cnt),
        .src     (s_q.mode.src),
        .hblank  (hblank),
        .tick    (tick)
    );

    git_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .gen     (s_q.mode.gen),
        .gsrc    (s_q.mode.gsrc),
        .gmode   (s_q.mode.gmode),
        .gate_in (gate_in),
        .hblank  (hblank),
        .allow   (gate_allow),
        .clear   (gate_clear)
    );

    always_comb begin
        s_d     = s_q;
        step    = tick && s_q.mode.run && gate_allow && !gate_clear && !wr_cnt;
        match   = (s_q.count == s_q.comp);
        at_top  = &s_q.count;
        equ_set = step && match;
        ovf_set = step && at_top && !(match && s_q.mode.zret);

        if (step) begin
            if (match && s_q.mode.zret) s_d.count = '0;
            else                        s_d.count = s_q.count + 1'b1;
        end
        if (gate_clear) s_d.count = '0;
        if (wr_cnt)     s_d.count = wdata[CNT_W-1:0];
        if (wr_cmp)     s_d.comp  = wdata[CNT_W-1:0];

        if (wr_mode) begin
            s_d.mode     = mode_wr;
            s_d.mode.equ = s_q.mode.equ & ~mode_wr.equ;
            s_d.mode.ovf = s_q.mode.ovf & ~mode_wr.ovf;
        end
        s_d.mode.equ = s_d.mode.equ | equ_set;
        s_d.mode.ovf = s_d.mode.ovf | ovf_set;

        if (HAS_HOLD && capture) s_d.hold = s_q.count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        if (HAS_HOLD) begin : g_hold
            assign hold_rd = s_q.hold;
        end else begin : g_nohold
            assign hold_rd = '0;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (hit) begin
            unique case (sel)
                2'd0:    rdata = DATA_W'(s_q.count);
                2'd1:    rdata = DATA_W'(s_q.mode);
                2'd2:    rdata = DATA_W'(s_q.comp);
                default: rdata = DATA_W'(hold_rd);
            endcase
        end
    end

    assign irq = (s_q.mode.equ & s_q.mode.cmp_ie) | (s_q.mode.ovf & s_q.mode.ovf_ie);
endmodule

// File: rtl/git_checker.sv
module git_checker #(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 32,
    parameter bit HAS_HOLD = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_cnt,
    input logic              wr_mode,
    input logic [CNT_W-1:0]  wdata_lo,
    input logic              clr_equ_bit,
    input logic              run,
    input logic              gate_clear,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  hold,
    input logic              capture,
    input logic              equ,
    input logic              ovf,
    input logic              irq,
    input logic [DATA_W-1:0] rdata
);
    // R1: upper read bits stay zero
    p_rdata_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:CNT_W] == '0);

    // R2: a count write lands at the next edge
    p_count_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> count == $past(wdata_lo));

    // R3: stopped counter holds
    p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt && !gate_clear) |=> $stable(count));

    // R8: equal flag is sticky unless cleared by a one
    p_equ_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (equ && !(wr_mode && clr_equ_bit)) |=> equ);

    // R9: no flag, no interrupt
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!equ && !ovf) |-> !irq);

    generate
        if (HAS_HOLD) begin : g_hold_chk
            // R11: capture copies the count
            p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
                capture |=> hold == $past(count));
        end
    endgenerate
endmodule

bind gated_interval_timer git_checker #(
    .CNT_W    (CNT_W),
    .DATA_W   (DATA_W),
    .HAS_HOLD (HAS_HOLD)
) u_git_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_cnt      (wr_cnt),
    .wr_mode     (wr_mode),
    .wdata_lo    (wdata[CNT_W-1:0]),
    .clr_equ_bit (wdata[10]),
    .run         (s_q.mode.run),
    .gate_clear  (gate_clear),
    .count       (s_q.count),
    .hold        (s_q.hold),
    .capture     (capture),
    .equ         (s_q.mode.equ),
    .ovf         (s_q.mode.ovf),
    .irq         (irq),
    .rdata       (rdata)
);

// File: tb/tb_gated_interval_timer.sv
module tb_gated_interval_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        hblank = 1'b0;
    logic        gate_in = 1'b0;
    logic        capture = 1'b0;
    wire  [31:0] rdata;
    wire         irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .hblank(hblank), .gate_in(gate_in), .capture(capture), .irq(irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t sb[$];
    event  ev_rd;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    localparam logic [7:0] A_CNT = 8'h00, A_MODE = 8'h10, A_CMP = 8'h20, A_HOLD = 8'h30;

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] v, input string tag);
        item_t it;
        @(negedge clk);
        addr = a;
        it.is_irq = 1'b0; it.val = v; it.tag = tag;
        sb.push_back(it);
        -> ev_rd;
        #2;
    endtask

    task automatic expect_irq(input logic v, input string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.val = {31'b0, v}; it.tag = tag;
        sb.push_back(it);
        -> ev_rd;
        #2;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic blank_pulse();
        @(negedge clk) hblank = 1'b1;
        repeat (3) @(negedge clk);
        hblank = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pops expected items and compares against the live outputs
    initial begin
        item_t it;
        logic [31:0] act;
        forever begin
            @(ev_rd);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                act = it.is_irq ? {31'b0, irq} : rdata;
                checks++;
                if (act !== it.val) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.val);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state and map
        expect_rd(A_CNT,  32'h0, "R1 reset count");
        expect_rd(A_MODE, 32'h0, "R1 reset mode");
        expect_rd(A_CMP,  32'h0, "R1 reset compare");
        expect_rd(A_HOLD, 32'h0, "R11 reset capture");
        expect_rd(8'h08,  32'h0, "R1 unmapped offset");
        expect_irq(1'b0, "R9 reset irq");

        wr(A_CMP, 32'h0000_7777);
        expect_rd(A_CMP, 32'h7777, "R1 compare readback");

        // R3 stopped counter, R2 immediate load, R1 upper bits
        wr(A_CNT, 32'hABCD_1234);
        expect_rd(A_CNT, 32'h1234, "R1 upper bits dropped");
        wr(A_CNT, 32'h5);
        edges(3);
        expect_rd(A_CNT, 32'h5, "R3 no count while run is 0");

        // R4 source 0: every clock
        wr(A_MODE, 32'h80);
        wr(A_CNT, 32'h0);
        expect_rd(A_CNT, 32'h0, "R2 count write effective");
        edges(4);
        expect_rd(A_CNT, 32'h4, "R4 bus clock source");

        // R4 source 1: divide by 16
        wr(A_MODE, 32'h81);
        wr(A_CNT, 32'h0);
        edges(15);
        expect_rd(A_CNT, 32'h0, "R4 div16 before first tick");
        edges(1);
        expect_rd(A_CNT, 32'h1, "R4 div16 first tick");
        edges(16);
        expect_rd(A_CNT, 32'h2, "R4 div16 second tick");

        // R4 source 2: divide by 256
        wr(A_MODE, 32'h82);
        wr(A_CNT, 32'h0);
        edges(255);
        expect_rd(A_CNT, 32'h0, "R4 div256 before first tick");
        edges(1);
        expect_rd(A_CNT, 32'h1, "R4 div256 first tick");

        // R4 source 3: blank strobe rising edges
        wr(A_MODE, 32'h83);
        wr(A_CNT, 32'h0);
        blank_pulse();
        blank_pulse();
        blank_pulse();
        expect_rd(A_CNT, 32'h3, "R4 blank strobe edges");

        // R10 level gate on gate_in
        gate_in = 1'b1;
        wr(A_MODE, 32'h84);
        wr(A_CNT, 32'h0);
        edges(3);
        expect_rd(A_CNT, 32'h0, "R10 level gate high blocks");
        @(negedge clk) gate_in = 1'b0;
        edges(3);
        expect_rd(A_CNT, 32'h3, "R10 level gate low counts");

        // R10 level gate sourced from hblank
        wr(A_MODE, 32'h8C);
        hblank = 1'b1;
        wr(A_CNT, 32'h0);
        edges(3);
        expect_rd(A_CNT, 32'h0, "R10 gate source hblank blocks");
        @(negedge clk) hblank = 1'b0;

        // R10 rising-edge clear
        wr(A_MODE, 32'h94);
        wr(A_CNT, 32'h100);
        edges(2);
        expect_rd(A_CNT, 32'h102, "R10 rise mode counts freely");
        @(negedge clk) gate_in = 1'b1;
        edges(1);
        edges(2);
        expect_rd(A_CNT, 32'h2, "R10 rising edge clears");

        // R10 falling-edge clear
        wr(A_MODE, 32'hA4);
        wr(A_CNT, 32'h10);
        @(negedge clk) gate_in = 1'b0;
        edges(1);
        edges(1);
        expect_rd(A_CNT, 32'h1, "R10 falling edge clears");

        // R10 both edges
        wr(A_MODE, 32'hB4);
        wr(A_CNT, 32'h20);
        @(negedge clk) gate_in = 1'b1;
        edges(1);
        expect_rd(A_CNT, 32'h0, "R10 either edge clears");

        // R5 zero-return on match
        wr(A_MODE, 32'h0);
        wr(A_CMP, 32'h3);
        wr(A_CNT, 32'h0);
        wr(A_MODE, 32'h1C0);
        edges(4);
        expect_rd(A_CNT, 32'h0, "R5 zero-return count");
        expect_rd(A_MODE, 32'h5C0, "R5 equal flag set");
        expect_irq(1'b1, "R9 irq on equal");
        wr(A_MODE, 32'h140);
        expect_rd(A_MODE, 32'h540, "R8 writing zero keeps flag");
        wr(A_MODE, 32'h540);
        expect_rd(A_MODE, 32'h140, "R8 write one clears equal");
        expect_irq(1'b0, "R9 irq drops after clear");

        // R6 match without zero-return keeps counting
        wr(A_CNT, 32'h2);
        wr(A_MODE, 32'h180);
        edges(2);
        expect_rd(A_CNT, 32'h4, "R6 count continues past match");
        wr(A_MODE, 32'h100);
        expect_rd(A_MODE, 32'h500, "R6 equal flag set");
        wr(A_MODE, 32'h500);

        // R7 wrap and overflow flag
        wr(A_CNT, 32'hFFFE);
        wr(A_MODE, 32'h280);
        edges(2);
        expect_rd(A_CNT, 32'h0, "R7 wrap to zero");
        wr(A_MODE, 32'h200);
        expect_rd(A_MODE, 32'hA00, "R7 overflow flag set");
        expect_irq(1'b1, "R9 irq on overflow");
        wr(A_MODE, 32'h000);
        expect_irq(1'b0, "R9 irq off when enable clear");
        wr(A_MODE, 32'h800);
        expect_rd(A_MODE, 32'h0, "R8 write one clears overflow");

        // R11 capture register
        wr(A_MODE, 32'h80);
        wr(A_CNT, 32'h0);
        edges(3);
        @(negedge clk) capture = 1'b1;
        @(posedge clk);
        #1 capture = 1'b0;
        expect_rd(A_HOLD, 32'h3, "R11 capture copies count");
        wr(A_HOLD, 32'h55);
        expect_rd(A_HOLD, 32'h3, "R11 capture ignores writes");

        edges(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule